// File: doc/BRIEF.md
# Change-of-Input Interrupt Detector

This block watches sixteen digital I/O channels and raises an interrupt when a channel that is acting as an input changes level. Every clock it registers the pin levels into an input register. It compares that sample with the sample from the cycle before. A change on an enabled input channel latches a per-channel change flag. The flags are presented as a low byte (channels 0-7) and a high byte (channels 8-15), so software can see which channel moved.

The channels are grouped in nibbles of four, and each nibble has a direction bit. Output nibbles never raise change flags. When a nibble is turned from input to output, its pending flags are dropped. Flags hold until an end-of-interrupt strobe clears them. While any flag is set, the active-low interrupt pin is driven low. In serial mode, one of two active-high status lines, picked by a select input, also shows the interrupt.

Top module: `coi_irq_unit`

## Requirements
- R1: `inputReg` bit x equals the level on `pinLevel` bit x at the previous rising clock edge, where 1 means high and 0 means low.
- R2: A level change on input-mode channel x with its enable bit set (`enLo` bit x for x<8, `enHi` bit x-8 otherwise) sets change flag x. The flag is seen in `msgLo` bit x or `msgHi` bit x-8 two rising edges after the new level is presented.
- R3: A level change on a channel whose enable bit is 0 sets no flag.
- R4: `intN` is 0 exactly when at least one change flag is set.
- R5: With `serialMode`=1, `statusLineA` (when `statSel`=0) or `statusLineB` (when `statSel`=1) equals the inverse of `intN`, and the other line is 0. With `serialMode`=0, both lines are 0.
- R6: Change flags stay set until `eoiStrobe` is 1 at a rising edge. That edge clears every flag.
- R7: A change detected on the same edge as `eoiStrobe` sets its flag, and the strobe clears only the older flags.
- R8: Channels in a nibble whose `dirOut` bit is 1 (output mode; nibble n holds channels 4n to 4n+3) never set change flags.
- R9: When a `dirOut` bit goes from 0 to 1, the flags of that nibble are cleared on that edge. Other nibbles keep their flags, and a 1-to-0 change clears nothing.
- R10: During reset all flags are 0, `intN` is 1 and `inputReg` is 0. The first sample taken after reset sets no flag, whatever the pin levels are.
- R11: Rising and falling levels both count as changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinLevel | input | 16 | Synchronized channel levels |
| dirOut | input | 4 | Per-nibble direction, 1 = output |
| enLo | input | 8 | Change enables, channels 0-7 |
| enHi | input | 8 | Change enables, channels 8-15 |
| eoiStrobe | input | 1 | End-of-interrupt, clears flags |
| serialMode | input | 1 | Enables the serial status lines |
| statSel | input | 1 | Picks which status line carries the interrupt |
| inputReg | output | 16 | Sampled channel levels |
| msgLo | output | 8 | Change flags, channels 0-7 |
| msgHi | output | 8 | Change flags, channels 8-15 |
| intN | output | 1 | Active-low interrupt |
| statusLineA | output | 1 | Active-high interrupt copy, select 0 |
| statusLineB | output | 1 | Active-high interrupt copy, select 1 |

## Verification
Two things can land on the same clock edge: the clear done by the end-of-interrupt strobe and the setting of a flag by a newly detected change. The bench first leaves an old flag pending. It then presents a new level on another channel and raises the strobe one cycle later, so the comparison and the clear hit the same edge. The check passes only when the old flag is gone, the new one is set and the interrupt is still asserted.

// File: rtl/coi_pkg.sv
package coi_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic warm;    // previous-sample register holds a real sample
    logic eoiClr;  // end-of-interrupt clear this edge
  } coiStrobe_t;
endpackage

// File: rtl/coi_ctrl.sv
module coi_ctrl #(
  parameter int NUM_NIB = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    eoiStrobe,
  input  logic [NUM_NIB-1:0]      dirOut,
  output coi_pkg::coiStrobe_t     strobes,
  output logic [NUM_NIB-1:0]      wipeNib,
  output logic [NUM_NIB-1:0]      inNib
);
  logic               primedQ;
  logic [NUM_NIB-1:0] dirQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primedQ <= 1'b0;
      dirQ    <= '0;
    end else begin
      primedQ <= 1'b1;
      dirQ    <= dirOut;
    end
  end

  always_comb begin
    strobes.warm   = primedQ;
    strobes.eoiClr = eoiStrobe;
    wipeNib        = dirOut & ~dirQ;
    inNib          = ~dirOut;
  end
endmodule

// File: rtl/coi_datapath.sv
module coi_datapath #(
  parameter int NIB_W   = 4,
  parameter int NUM_NIB = 4,
  localparam int NUM_CH = NIB_W * NUM_NIB
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CH-1:0]    pinLevel,
  input  logic [NUM_CH-1:0]    chanEn,
  input  coi_pkg::coiStrobe_t  strobes,
  input  logic [NUM_NIB-1:0]   wipeNib,
  input  logic [NUM_NIB-1:0]   inNib,
  output logic [NUM_CH-1:0]    sampleOut,
  output logic [NUM_CH-1:0]    flagOut
);
  logic [NUM_CH-1:0] sampleQ;
  logic [NUM_CH-1:0] prevQ;
  logic [NUM_CH-1:0] changed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleQ <= '0;
      prevQ   <= '0;
    end else if (!strobes.warm) begin
      sampleQ <= pinLevel;  // first sample primes both stages
      prevQ   <= pinLevel;
    end else begin
      sampleQ <= pinLevel;
      prevQ   <= sampleQ;
    end
  end

  assign changed   = {NUM_CH{strobes.warm}} & (sampleQ ^ prevQ);
  assign sampleOut = sampleQ;

  for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
    for (genvar b = 0; b < NIB_W; b++) begin : g_ch
      localparam int CH = n * NIB_W + b;
      logic flagQ;
      logic setHit;
      assign setHit = changed[CH] & chanEn[CH] & inNib[n];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              flagQ <= 1'b0;
        else if (wipeNib[n])    flagQ <= 1'b0;
        else if (setHit)        flagQ <= 1'b1;
        else if (strobes.eoiClr) flagQ <= 1'b0;
      end
      assign flagOut[CH] = flagQ;
    end
  end
endmodule

// File: rtl/coi_irq_unit.sv
module coi_irq_unit #(
  parameter int NIB_W   = 4,
  parameter int NUM_NIB = 4,
  localparam int NUM_CH = NIB_W * NUM_NIB,
  localparam int HALF   = NUM_CH / 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CH-1:0]  pinLevel,
  input  logic [NUM_NIB-1:0] dirOut,
  input  logic [HALF-1:0]    enLo,
  input  logic [HALF-1:0]    enHi,
  input  logic               eoiStrobe,
  input  logic               serialMode,
  input  logic               statSel,
  output logic [NUM_CH-1:0]  inputReg,
  output logic [HALF-1:0]    msgLo,
  output logic [HALF-1:0]    msgHi,
  output logic               intN,
  output logic               statusLineA,
  output logic               statusLineB
);
  coi_pkg::coiStrobe_t strobes;
  logic [NUM_NIB-1:0]  wipeNib;
  logic [NUM_NIB-1:0]  inNib;
  logic [NUM_CH-1:0]   flags;
  logic                irqActive;

  coi_ctrl #(.NUM_NIB(NUM_NIB)) ctrl_i (
    .clk(clk), .rstN(rstN), .eoiStrobe(eoiStrobe), .dirOut(dirOut),
    .strobes(strobes), .wipeNib(wipeNib), .inNib(inNib)
  );

  coi_datapath #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) dp_i (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .chanEn({enHi, enLo}),
    .strobes(strobes), .wipeNib(wipeNib), .inNib(inNib),
    .sampleOut(inputReg), .flagOut(flags)
  );

  assign irqActive   = |flags;
  assign intN        = ~irqActive;
  assign msgLo       = flags[HALF-1:0];
  assign msgHi       = flags[NUM_CH-1:HALF];
  assign statusLineA = serialMode & ~statSel & irqActive;
  assign statusLineB = serialMode &  statSel & irqActive;
endmodule

// File: rtl/coi_irq_checker.sv
module coi_irq_checker #(
  parameter int NIB_W   = 4,
  parameter int NUM_NIB = 4,
  localparam int NUM_CH = NIB_W * NUM_NIB,
  localparam int HALF   = NUM_CH / 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_CH-1:0]  pinLevel,
  input logic [NUM_NIB-1:0] dirOut,
  input logic               eoiStrobe,
  input logic               serialMode,
  input logic [NUM_CH-1:0]  inputReg,
  input logic [HALF-1:0]    msgLo,
  input logic [HALF-1:0]    msgHi,
  input logic               intN,
  input logic               statusLineA,
  input logic               statusLineB
);
  logic [1:0]        armCnt;
  logic              armed;
  logic [NUM_CH-1:0] msgs;
  logic [NUM_CH-1:0] outMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               armCnt <= '0;
    else if (armCnt != 2'd2) armCnt <= armCnt + 2'd1;
  end
  assign armed = (armCnt == 2'd2);
  assign msgs  = {msgHi, msgLo};

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) outMask[c] = dirOut[c / NIB_W];
  end

  a_r1_input_sample: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> inputReg == $past(pinLevel));

  a_r4_intn_matches: assert property (@(posedge clk) disable iff (!rstN)
    intN == (msgs == '0));

  a_r5_status_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({statusLineA, statusLineB}));

  a_r5_status_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !serialMode |-> (!statusLineA && !statusLineB));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(eoiStrobe) && (($past(dirOut) & ~$past(dirOut, 2)) == '0))
      |-> ((msgs & $past(msgs)) == $past(msgs)));

  a_r8_output_quiet: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> ((msgs & ~$past(msgs) & $past(outMask)) == '0));
endmodule

bind coi_irq_unit coi_irq_checker #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB)) chk_i (
  .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .dirOut(dirOut),
  .eoiStrobe(eoiStrobe), .serialMode(serialMode), .inputReg(inputReg),
  .msgLo(msgLo), .msgHi(msgHi), .intN(intN),
  .statusLineA(statusLineA), .statusLineB(statusLineB)
);

// File: tb/coi_irq_unit_tb_top.sv
`timescale 1ns/1ps
module coi_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pinLevel = 16'hFFFF;
  logic [3:0]  dirOut = '0;
  logic [7:0]  enLo = '0, enHi = '0;
  logic        eoiStrobe = 1'b0, serialMode = 1'b1, statSel = 1'b0;
  logic [15:0] inputReg;
  logic [7:0]  msgLo, msgHi;
  logic        intN, statusLineA, statusLineB;
  int nChecks = 0, nFails = 0;

  always #10 clk = ~clk;

  coi_irq_unit dut_i (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .dirOut(dirOut),
    .enLo(enLo), .enHi(enHi), .eoiStrobe(eoiStrobe), .serialMode(serialMode),
    .statSel(statSel), .inputReg(inputReg), .msgLo(msgLo), .msgHi(msgHi),
    .intN(intN), .statusLineA(statusLineA), .statusLineB(statusLineB)
  );

  typedef struct packed {
    logic [15:0] pin;
    logic [15:0] en;
    logic [3:0]  dir;
    logic        eoi;
    logic [15:0] expF;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0000, 4'h0, 1'b0, 16'h0000}, // R3 all disabled
    '{16'h0001, 16'hFFFF, 4'h0, 1'b0, 16'h0001}, // R2 rise ch0
    '{16'h0001, 16'hFFFF, 4'h0, 1'b1, 16'h0000}, // R6 clear
    '{16'h8101, 16'h00FF, 4'h0, 1'b0, 16'h0000}, // R3 ch8/ch15 disabled
    '{16'h8103, 16'hFFFF, 4'h0, 1'b0, 16'h0002}, // R2 ch1
    '{16'h0103, 16'hFFFF, 4'h0, 1'b0, 16'h8002}, // R11 fall ch15, R6 sticky
    '{16'h0103, 16'hFFFF, 4'h1, 1'b0, 16'h8000}, // R9 wipe nibble 0
    '{16'h010C, 16'hFFFF, 4'h1, 1'b0, 16'h8000}, // R8 output nibble quiet
    '{16'h010C, 16'hFFFF, 4'h0, 1'b0, 16'h8000}, // R9 back to input, no wipe
    '{16'h110C, 16'hFFFF, 4'h0, 1'b0, 16'h9000}, // R2 ch12
    '{16'h110C, 16'hFFFF, 4'h8, 1'b0, 16'h0000}, // R9 wipe nibble 3
    '{16'h0000, 16'hFFFF, 4'h8, 1'b0, 16'h010C}, // R8 ch12 ignored
    '{16'h0000, 16'hFFFF, 4'h0, 1'b1, 16'h0000}  // R6 clear
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    // R10 reset state with pins high
    repeat (3) @(negedge clk);
    chk("R10 reset inputReg", 32'(inputReg), 32'h0);
    chk("R10 reset msgs", 32'({msgHi, msgLo}), 32'h0);
    chk("R10 reset intN", 32'(intN), 32'h1);
    rstN = 1'b1;
    enLo = 8'hFF; enHi = 8'hFF;
    repeat (3) tick();
    chk("R10 no flag on first sample", 32'({msgHi, msgLo}), 32'h0);
    chk("R1 inputReg high", 32'(inputReg), 32'hFFFF);

    // table: R2 R3 R4 R5 R6 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      pinLevel  = VECS[i].pin;
      {enHi, enLo} = VECS[i].en;
      dirOut    = VECS[i].dir;
      eoiStrobe = VECS[i].eoi;
      @(posedge clk);
      @(negedge clk);
      eoiStrobe = 1'b0;
      tick();
      #1;
      $display("vector %0d", i);
      chk("R2/R3/R6/R8/R9/R11 msgs", 32'({msgHi, msgLo}), 32'(VECS[i].expF));
      chk("R1 inputReg", 32'(inputReg), 32'(VECS[i].pin));
      chk("R4 intN", 32'(intN), 32'(VECS[i].expF == 16'h0));
      chk("R5 statusLineA", 32'(statusLineA), 32'(VECS[i].expF != 16'h0));
    end

    // R7: new change on the same edge as end-of-interrupt
    pinLevel = 16'h0001;
    tick(); tick();
    chk("R2 pre-R7 flag", 32'({msgHi, msgLo}), 32'h0001);
    pinLevel = 16'h0201;
    tick();
    eoiStrobe = 1'b1;
    tick();
    eoiStrobe = 1'b0;
    #1;
    chk("R7 new edge wins over clear", 32'({msgHi, msgLo}), 32'h0200);
    chk("R7 intN held", 32'(intN), 32'h0);

    // R5 status line selection
    statSel = 1'b1; #1;
    chk("R5 lineB selected", 32'({statusLineA, statusLineB}), 32'h1);
    serialMode = 1'b0; #1;
    chk("R5 serial off", 32'({statusLineA, statusLineB}), 32'h0);
    serialMode = 1'b1; statSel = 1'b0; #1;
    chk("R5 lineA selected", 32'({statusLineA, statusLineB}), 32'h2);
    eoiStrobe = 1'b1;
    tick();
    eoiStrobe = 1'b0;
    #1;
    chk("R6 cleared", 32'({msgHi, msgLo}), 32'h0);
    chk("R5 lineA idle", 32'(statusLineA), 32'h0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule